// File: doc/BRIEF.md
# Quadrature FIR Phase Splitter

This block takes a stream of signed real samples and produces an in-phase and a quadrature output for each accepted sample. Two FIR filters run side by side. Each passband is centred on a quarter of the sample rate, and the quadrature filter's impulse response is the in-phase response reversed in time, so the two outputs lie 90° apart across the passband. The outputs feed modulators or image-rejection stages downstream.

Because of the quarter-rate centring, every odd-indexed coefficient of the in-phase filter is zero. Each remaining product of the input with a nonzero coefficient is formed once by a shift-and-add network in canonic signed-digit form. That product is injected at tap k of the in-phase chain and at tap TAPS−1−k of the quadrature chain. Both chains use the transposed form: the sample is broadcast to every product, and partial sums move one register toward the output per accepted sample. A tap count of TAPS therefore needs only TAPS/2 constant multipliers. Each output is rounded to nearest and saturated to the sample width.

Top module: `qpsSplitter`

## Requirements
- R1: A synchronous active-high `rst` clears every delay register, `outI`, `outQ` and `outValid` to zero. The first cycle after reset shows all three at zero, and later outputs depend only on samples accepted after reset.
- R2: `outValid` is high in exactly the cycle after a cycle in which `inValid` was high, so the latency is one register stage.
- R3: For the n-th accepted sample, `outI` equals round(yI/2^15) with yI = Σ c[k]·x[n−k] for k = 0..TAPS−1. Samples before reset count as zero. The coefficients are c[2m] = (−1)^m·(2048 + 1229·m) and c[2m+1] = 0.
- R4: `outQ` uses the same rule with coefficients cQ[k] = c[TAPS−1−k], the in-phase set reversed in time.
- R5: A cycle with `inValid` low moves no delay register and leaves `outI` and `outQ` unchanged. A stream with idle gaps produces the same output sequence as the same stream without gaps.
- R6: Rounding adds 2^14 and then shifts right arithmetically by 15, so an exact half rounds toward plus infinity. An exact +0.5 becomes 1, −0.5 becomes 0, and −1.5 becomes −1.
- R7: A rounded value above 32767 gives 32767, and one below −32768 gives −32768.
- R8: With TAPS = 32 the same rules R2 to R7 hold, using 16 shared multipliers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Sample strobe; the chains advance only when high |
| inSample | input | 16 | Signed input sample |
| outValid | output | 1 | High one cycle after an accepted sample |
| outI | output | 16 | Signed in-phase output |
| outQ | output | 16 | Signed quadrature output |

## Verification
The assertions take for granted that `inSample` holds a defined value on every cycle outside reset, including idle cycles, because the product check compares the shift-and-add result with a true multiply on every clock edge. They also assume that `inValid` is the only thing that moves the chains and that `rst` is held for at least one edge before the first sample. The bench drives both inputs on the falling edge, always with a defined value, and never leaves `inSample` unset during idle cycles. It mixes seeded random samples and idle gaps with impulses, full-scale steps of both signs, a pattern that drives the sums into saturation, half-value rounding cases and a reset in the middle of a run.

// File: rtl/qpsPkg.sv
package qpsPkg;

  // Strobes that the control half hands to the datapath.
  typedef struct packed {
    logic advance;   // shift both transposed chains by one sample
    logic capture;   // load the rounded outputs
  } qpsStrobe_t;

  // In-phase coefficient set, Q1.15. Odd taps are zero (quarter-rate centring).
  function automatic int coefAt(input int k);
    int m;
    int mag;
    if ((k % 2) != 0) return 0;
    m   = k / 2;
    mag = 2048 + 1229 * m;
    return ((m % 2) != 0) ? -mag : mag;
  endfunction

  // Canonic signed-digit decomposition: digit (-1, 0, +1) at a given weight.
  function automatic int csdDigit(input int value, input int pos);
    int x;
    int d;
    x = value;
    d = 0;
    for (int i = 0; i <= pos; i++) begin
      d = 0;
      if ((x & 1) != 0) begin
        d = 2 - (x & 3);
        x = x - d;
      end
      x = x >>> 1;
    end
    return d;
  endfunction

endpackage

// File: rtl/qpsCsdMult.sv
module qpsCsdMult #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int COEF   = 0,
  localparam int PROD_W = DATA_W + COEF_W
) (
  input  logic signed [DATA_W-1:0] sample,
  output logic signed [PROD_W-1:0] product
);

  localparam int DIGITS = COEF_W + 1;

  logic signed [PROD_W-1:0] wideSample;
  logic signed [PROD_W-1:0] term [DIGITS];

  assign wideSample = PROD_W'(sample);

  for (genvar p = 0; p < DIGITS; p++) begin : g_digit
    localparam int DIGIT = qpsPkg::csdDigit(COEF, p);
    if (DIGIT > 0) begin : g_add
      assign term[p] = wideSample <<< p;
    end else if (DIGIT < 0) begin : g_sub
      assign term[p] = -(wideSample <<< p);
    end else begin : g_none
      assign term[p] = '0;
    end
  end

  always_comb begin
    product = '0;
    for (int p = 0; p < DIGITS; p++) begin
      product = product + term[p];
    end
  end

endmodule

// File: rtl/qpsTapChain.sv
module qpsTapChain #(
  parameter int TAPS   = 26,
  parameter int PROD_W = 32,
  parameter int ACC_W  = 37,
  parameter bit MIRROR = 1'b0,
  localparam int HALF  = TAPS / 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     advance,
  input  logic signed [PROD_W-1:0] prods [HALF],
  output logic signed [ACC_W-1:0]  chainSum
);

  logic signed [ACC_W-1:0] tapIn [TAPS];

  // Route each shared product to its tap; the mirrored chain reads the reversed index.
  for (genvar k = 0; k < TAPS; k++) begin : g_route
    localparam int SRC = MIRROR ? (TAPS - 1 - k) : k;
    if ((SRC % 2) == 0) begin : g_live
      assign tapIn[k] = ACC_W'(prods[SRC/2]);
    end else begin : g_zero
      assign tapIn[k] = '0;
    end
  end

  // Transposed form: stage k holds the partial sum that reaches the output k samples later.
  for (genvar k = 1; k < TAPS; k++) begin : g_stage
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] upstream;
    if (k == TAPS - 1) begin : g_end
      assign upstream = '0;
    end else begin : g_mid
      assign upstream = g_stage[k+1].acc;
    end
    always_ff @(posedge clk) begin
      if (rst)          acc <= '0;
      else if (advance) acc <= tapIn[k] + upstream;
    end
  end

  assign chainSum = tapIn[0] + g_stage[1].acc;

endmodule

// File: rtl/qpsControl.sv
module qpsControl (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output qpsPkg::qpsStrobe_t strobe,
  output logic              outValid
);

  assign strobe.advance = inValid;
  assign strobe.capture = inValid;

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= strobe.capture;
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |=> outValid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.capture |=> !outValid);

endmodule

// File: rtl/qpsDatapath.sv
module qpsDatapath #(
  parameter int TAPS   = 26,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  qpsPkg::qpsStrobe_t       strobe,
  input  logic signed [DATA_W-1:0] inSample,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ
);

  localparam int HALF   = TAPS / 2;
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(TAPS) + 1;

  localparam logic signed [ACC_W-1:0] SAT_HI   = (ACC_W'(1) <<< (DATA_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] SAT_LO   = -(ACC_W'(1) <<< (DATA_W - 1));
  localparam logic signed [ACC_W-1:0] BIAS     = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] OVER_HI  = ACC_W'(1) <<< (DATA_W - 1 + FRAC_W);
  localparam logic signed [ACC_W-1:0] UNDER_LO = -(ACC_W'(1) <<< (DATA_W - 1 + FRAC_W)) - (ACC_W'(1) <<< FRAC_W);

  logic signed [PROD_W-1:0] prods [HALF];
  logic signed [ACC_W-1:0]  sumI;
  logic signed [ACC_W-1:0]  sumQ;

  // One shift-and-add network per nonzero in-phase coefficient, shared by both chains.
  for (genvar m = 0; m < HALF; m++) begin : g_mult
    localparam int COEF = qpsPkg::coefAt(2 * m);
    qpsCsdMult #(
      .DATA_W(DATA_W),
      .COEF_W(COEF_W),
      .COEF  (COEF)
    ) uMult (
      .sample (inSample),
      .product(prods[m])
    );

    // R3
    csd_product_chk: assert property (@(posedge clk) disable iff (rst)
      longint'(prods[m]) == longint'(inSample) * longint'(COEF));
  end

  qpsTapChain #(
    .TAPS  (TAPS),
    .PROD_W(PROD_W),
    .ACC_W (ACC_W),
    .MIRROR(1'b0)
  ) uChainI (
    .clk     (clk),
    .rst     (rst),
    .advance (strobe.advance),
    .prods   (prods),
    .chainSum(sumI)
  );

  qpsTapChain #(
    .TAPS  (TAPS),
    .PROD_W(PROD_W),
    .ACC_W (ACC_W),
    .MIRROR(1'b1)
  ) uChainQ (
    .clk     (clk),
    .rst     (rst),
    .advance (strobe.advance),
    .prods   (prods),
    .chainSum(sumQ)
  );

  function automatic logic signed [DATA_W-1:0] roundSat(input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] scaled;
    scaled = (v + BIAS) >>> FRAC_W;
    if (scaled > SAT_HI)      return DATA_W'(SAT_HI);
    else if (scaled < SAT_LO) return DATA_W'(SAT_LO);
    else                      return DATA_W'(scaled);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      outI <= '0;
      outQ <= '0;
    end else if (strobe.capture) begin
      outI <= roundSat(sumI);
      outQ <= roundSat(sumQ);
    end
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.advance |=> ($stable(outI) && $stable(outQ)));

  // R7
  clip_high_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && sumI >= OVER_HI) |=> (outI == DATA_W'(SAT_HI)));

  // R7
  clip_low_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && sumQ <= UNDER_LO) |=> (outQ == DATA_W'(SAT_LO)));

endmodule

// File: rtl/qpsSplitter.sv
module qpsSplitter #(
  parameter int TAPS   = 26,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inSample,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ
);

  qpsPkg::qpsStrobe_t strobe;

  qpsControl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  qpsDatapath #(
    .TAPS  (TAPS),
    .DATA_W(DATA_W),
    .COEF_W(COEF_W),
    .FRAC_W(FRAC_W)
  ) uPath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inSample(inSample),
    .outI    (outI),
    .outQ    (outQ)
  );

endmodule

// File: tb/qpsSplitter_test.sv
`timescale 1ns/1ps
module qpsSplitter_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [15:0] inSample = '0;

  logic outValid, outValid32;
  logic signed [15:0] outI, outQ, outI32, outQ32;

  always #10 clk = ~clk;

  qpsSplitter #(.TAPS(26)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  qpsSplitter #(.TAPS(32)) uut32 (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .outValid(outValid32), .outI(outI32), .outQ(outQ32)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  longint hist [32];
  longint expI, expQ, expI32, expQ32;

  function automatic longint refCoef(input int k);
    longint m;
    if ((k % 2) != 0) return 0;
    m = k / 2;
    return ((m % 2) != 0) ? -(2048 + 1229 * m) : (2048 + 1229 * m);
  endfunction

  function automatic longint convolve(input int taps, input bit quad);
    longint acc;
    acc = 0;
    for (int k = 0; k < taps; k++) begin
      acc += (quad ? refCoef(taps - 1 - k) : refCoef(k)) * hist[k];
    end
    return acc;
  endfunction

  function automatic longint toOut(input longint y);
    longint q;
    q = (y + 16384) >>> 15;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clearModel();
    for (int k = 0; k < 32; k++) hist[k] = 0;
    expI = 0; expQ = 0; expI32 = 0; expQ32 = 0;
  endtask

  // Apply one cycle of stimulus at the falling edge and check one cycle later.
  task automatic step(input bit v, input logic signed [15:0] s, input string tagI, input string tagQ);
    string tI, tQ, t8;
    inValid = v;
    inSample = s;
    if (v) begin
      for (int k = 31; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'(s);
      expI   = toOut(convolve(26, 1'b0));
      expQ   = toOut(convolve(26, 1'b1));
      expI32 = toOut(convolve(32, 1'b0));
      expQ32 = toOut(convolve(32, 1'b1));
      tI = tagI; tQ = tagQ; t8 = "R8";
    end else begin
      tI = "R5"; tQ = "R5"; t8 = "R5/R8";
    end
    @(negedge clk);
    check(outValid == v, "R2", longint'(outValid), longint'(v));
    check(longint'(outI) == expI, tI, longint'(outI), expI);
    check(longint'(outQ) == expQ, tQ, longint'(outQ), expQ);
    check(outValid32 == v, "R8", longint'(outValid32), longint'(v));
    check(longint'(outI32) == expI32, t8, longint'(outI32), expI32);
    check(longint'(outQ32) == expQ32, t8, longint'(outQ32), expQ32);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b1;
    inSample = 16'sh5a5a;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    inValid = 1'b0;
    clearModel();
    // R1: everything cleared right after reset
    check(outValid == 1'b0 && outValid32 == 1'b0, "R1", longint'(outValid), 0);
    check(outI == 0 && outI32 == 0, "R1", longint'(outI), 0);
    check(outQ == 0 && outQ32 == 0, "R1", longint'(outQ), 0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h51ed_2026));
    clearModel();
    doReset();

    // R3/R4: positive and negative unit impulses trace out the coefficient sets
    step(1'b1, 16'sd32767, "R3", "R4");
    for (int i = 0; i < 33; i++) step(1'b1, 16'sd0, "R3", "R4");
    step(1'b1, -16'sd32768, "R3", "R4");
    for (int i = 0; i < 33; i++) step(1'b1, 16'sd0, "R3", "R4");

    // R3/R4: full-scale steps of both signs
    for (int i = 0; i < 40; i++) step(1'b1, 16'sd32767, "R3", "R4");
    for (int i = 0; i < 40; i++) step(1'b1, -16'sd32768, "R3", "R4");

    // R7: period-4 pattern aligned to the coefficient signs drives both sums past full scale
    for (int i = 0; i < 48; i++)
      step(1'b1, ((i % 4) < 2) ? 16'sd32767 : -16'sd32768, "R7", "R7");

    // R6: half-value rounding cases, each from an empty chain
    doReset(); step(1'b1, 16'sd8,   "R6", "R6"); step(1'b1, 16'sd0, "R6", "R6");
    doReset(); step(1'b1, -16'sd8,  "R6", "R6"); step(1'b1, 16'sd0, "R6", "R6");
    doReset(); step(1'b1, 16'sd24,  "R6", "R6"); step(1'b1, 16'sd0, "R6", "R6");
    doReset(); step(1'b1, -16'sd24, "R6", "R6"); step(1'b1, 16'sd0, "R6", "R6");

    // R5: random stream with idle gaps; idle cycles must not disturb state
    doReset();
    for (int i = 0; i < 600; i++) begin
      bit v;
      logic signed [15:0] s;
      v = ($urandom % 4) != 0;
      case ($urandom % 8)
        0:       s = 16'sh7fff;
        1:       s = -16'sh8000;
        default: s = 16'($urandom);
      endcase
      step(v, s, "R3", "R4");
      if (i == 300) begin
        // R1: reset mid-run empties the chains
        doReset();
        step(1'b1, 16'sd1000, "R1", "R1");
      end
    end

    finished = 1'b1;
    report();
    $finish;
  end

endmodule